// File: doc/BRIEF.md
# Digital I/O Port with Per-Pin Analog Gating

This block is an eight-pin general-purpose I/O port that sits on a small synchronous register bus inside a microcontroller-class chip. Each pin has four configuration bits: an output latch, a direction bit, an analog-select bit and a slew-select bit. The pad side of each pin carries an output value, an output enable, a slew control and a raw input. Pin inputs pass through a two-stage synchronizer before software can read them.

When a pin's analog-select bit is set, its digital input path is cut off and the pin reads as 0 at the port address. The output driver is not affected. A pin configured as output still drives its latch value while it is analog-selected. Writes to the port address land in the output latch. The latch also has its own address, so firmware can read back what it wrote even when pins are analog-selected or are being driven externally. After reset every pin is an analog input with its output off and its slew set to the reduced rate.

Reads are registered. `rdData` loads on a clock edge where `busRdEn` is high and holds its value otherwise.

Top module: `gpio_analog_port`

## Requirements
- R1: After reset the direction, analog-select and slew registers read all ones and the latch reads 0. `padOe` is 0, `padOut` is 0, `padSlowSlew` is all ones and `rdData` is 0.
- R2: A write to offset 0 (port) or offset 1 (latch) stores `busWrData` into the output latch. The latch reads back at offset 1, and `padOut` equals the latch from the edge after the write.
- R3: A read at offset 0 returns, for each pin, the synchronized pad input ANDed with the inverse of that pin's analog-select bit.
- R4: A pin whose analog-select bit is 1 reads as 0 at offset 0, whatever its pad input.
- R5: Writing the analog-select register (offset 3) changes neither `padOut` nor `padOe`. A pin with direction 0 and analog-select 1 still drives its latch value on `padOut` with `padOe` high.
- R6: The direction register (offset 2) reads back as written, and `padOe` is its bitwise inverse from the edge after the write.
- R7: A pad input change made just after edge N first becomes visible in `rdData` for a port read loaded at edge N+3.
- R8: A read at offset 1 returns the latch contents and does not depend on the pad inputs or the analog-select bits.
- R9: The slew register (offset 4) reads back as written, and `padSlowSlew` equals it from the edge after the write. A 1 selects the reduced rate.
- R10: Reads at offsets 5 to 7 return 0. Writes to those offsets change no register.
- R11: `rdData` changes only on an edge where `busRdEn` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous power-on / brown-out reset |
| busAddr | input | 3 | Register offset |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe; rdData loads on this edge |
| rdData | output | 8 | Registered read data |
| padIn | input | 8 | Raw pad input values |
| padOut | output | 8 | Pad output values (latch) |
| padOe | output | 8 | Pad output enables, 1 = drive |
| padSlowSlew | output | 8 | Pad slew control, 1 = reduced rate |

## Verification
The port read path is swept over all 256 pad patterns against several analog masks: none, all, alternating and single-bit walking. This separates a correct AND-gating from a missing gate, an inverted gate or a shifted mask. The latch is swept with all 256 values and read back under opposing pad inputs and full analog masking. That distinguishes latch readback from pin readback, which is what a read-modify-write depends on. A pad change is tracked cycle by cycle under a held read strobe to pin the synchronizer depth. Unmapped offsets are written with values and the mapped registers are then read back, which exposes a decoder that aliases them.

// File: rtl/gpio_analog_pkg.sv
package gpio_analog_pkg;

  typedef enum logic [2:0] {
    SEL_PORT  = 3'd0,
    SEL_LATCH = 3'd1,
    SEL_DIR   = 3'd2,
    SEL_ANA   = 3'd3,
    SEL_SLEW  = 3'd4,
    SEL_NONE  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrLatch;
    logic    wrDir;
    logic    wrAnalog;
    logic    wrSlew;
    logic    rdStrobe;
    regSel_e rdSel;
  } gpioStrobe_t;

endpackage

// File: rtl/gpio_analog_ctrl.sv
module gpio_analog_ctrl
  import gpio_analog_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output gpioStrobe_t       strobes
);

  localparam logic [ADDR_W-1:0] OFF_PORT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_LATCH = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF_DIR   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFF_ANA   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFF_SLEW  = ADDR_W'(4);

  regSel_e selDecoded;

  always_comb begin
    unique case (busAddr)
      OFF_PORT:  selDecoded = SEL_PORT;
      OFF_LATCH: selDecoded = SEL_LATCH;
      OFF_DIR:   selDecoded = SEL_DIR;
      OFF_ANA:   selDecoded = SEL_ANA;
      OFF_SLEW:  selDecoded = SEL_SLEW;
      default:   selDecoded = SEL_NONE;
    endcase
  end

  always_comb begin
    // the port address and the latch address both feed the output latch
    strobes.wrLatch  = busWrEn && (selDecoded == SEL_PORT || selDecoded == SEL_LATCH);
    strobes.wrDir    = busWrEn && (selDecoded == SEL_DIR);
    strobes.wrAnalog = busWrEn && (selDecoded == SEL_ANA);
    strobes.wrSlew   = busWrEn && (selDecoded == SEL_SLEW);
    strobes.rdStrobe = busRdEn;
    strobes.rdSel    = selDecoded;
  end

endmodule

// File: rtl/gpio_analog_datapath.sv
module gpio_analog_datapath
  import gpio_analog_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gpioStrobe_t          strobes,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] rdData,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padSlowSlew,
  output logic [PIN_COUNT-1:0] analogBits
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;
  localparam logic [PIN_COUNT-1:0] ALL_ONES = {PIN_COUNT{1'b1}};

  logic [PIN_COUNT-1:0] latchQ, dirQ, analogQ, slewQ;
  logic [SYNC_STAGES-1:0][PIN_COUNT-1:0] syncQ;
  logic [PIN_COUNT-1:0] portView, rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ  <= '0;
      dirQ    <= ALL_ONES;
      analogQ <= ALL_ONES;
      slewQ   <= ALL_ONES;
    end else begin
      if (strobes.wrLatch)  latchQ  <= wrData;
      if (strobes.wrDir)    dirQ    <= wrData;
      if (strobes.wrAnalog) analogQ <= wrData;
      if (strobes.wrSlew)   slewQ   <= wrData;
    end
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= '0;
          else       syncQ[0] <= padIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= '0;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  // an analog-selected pin reads 0; the output path ignores analogQ
  assign portView = syncQ[LAST_STAGE] & ~analogQ;

  always_comb begin
    unique case (strobes.rdSel)
      SEL_PORT:  rdNext = portView;
      SEL_LATCH: rdNext = latchQ;
      SEL_DIR:   rdNext = dirQ;
      SEL_ANA:   rdNext = analogQ;
      SEL_SLEW:  rdNext = slewQ;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rdData <= '0;
    else if (strobes.rdStrobe) rdData <= rdNext;
  end

  assign padOut      = latchQ;
  assign padOe       = ~dirQ;
  assign padSlowSlew = slewQ;
  assign analogBits  = analogQ;

endmodule

// File: rtl/gpio_analog_port.sv
module gpio_analog_port
  import gpio_analog_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [PIN_COUNT-1:0] busWrData,
  input  logic                 busRdEn,
  output logic [PIN_COUNT-1:0] rdData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padSlowSlew
);

  gpioStrobe_t          strobes;
  logic [PIN_COUNT-1:0] analogBits;

  gpio_analog_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobes (strobes)
  );

  gpio_analog_datapath #(
    .PIN_COUNT  (PIN_COUNT),
    .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (busWrData),
    .padIn      (padIn),
    .rdData     (rdData),
    .padOut     (padOut),
    .padOe      (padOe),
    .padSlowSlew(padSlowSlew),
    .analogBits (analogBits)
  );

endmodule

// File: rtl/gpio_analog_port_chk.sv
module gpio_analog_port_chk #(
  parameter int PIN_COUNT = 8,
  parameter int ADDR_W    = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic [PIN_COUNT-1:0] busWrData,
  input logic                 busRdEn,
  input logic [PIN_COUNT-1:0] rdData,
  input logic [PIN_COUNT-1:0] padOut,
  input logic [PIN_COUNT-1:0] padOe,
  input logic [PIN_COUNT-1:0] padSlowSlew,
  input logic [PIN_COUNT-1:0] analogBits
);

  // R2
  latch_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == ADDR_W'(0) || busAddr == ADDR_W'(1))) |=> (padOut == $past(busWrData)));

  // R4
  analog_gates_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(0)) |=> ((rdData & $past(analogBits)) == '0));

  // R5
  analog_output_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(3)) |=> ($stable(padOut) && $stable(padOe)));

  // R6
  dir_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(2)) |=> (padOe == ~$past(busWrData)));

  // R9
  slew_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(4)) |=> (padSlowSlew == $past(busWrData)));

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr > ADDR_W'(4)) |=> (rdData == '0));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(rdData));

endmodule

bind gpio_analog_port gpio_analog_port_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWrEn    (busWrEn),
  .busWrData  (busWrData),
  .busRdEn    (busRdEn),
  .rdData     (rdData),
  .padOut     (padOut),
  .padOe      (padOe),
  .padSlowSlew(padSlowSlew),
  .analogBits (analogBits)
);

// File: tb/tb_gpio_analog_port.sv
`timescale 1ns/1ps
module tb_gpio_analog_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic       busRdEn = 1'b0;
  logic [7:0] rdData;
  logic [7:0] padIn = '0;
  logic [7:0] padOut, padOe, padSlowSlew;

  int checks = 0;
  int errors = 0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  gpio_analog_port dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .rdData(rdData),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padSlowSlew(padSlowSlew)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = rdData;
  endtask

  task automatic setPins(input logic [7:0] v);
    @(negedge clk);
    padIn = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [7:0] masks [6];
    masks[0] = 8'h00; masks[1] = 8'hFF; masks[2] = 8'hAA;
    masks[3] = 8'h55; masks[4] = 8'h0F; masks[5] = 8'h81;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 padOe", padOe, 8'h00);
    check("R1 padOut", padOut, 8'h00);
    check("R1 padSlowSlew", padSlowSlew, 8'hFF);
    check("R1 rdData", rdData, 8'h00);
    rstN = 1'b1;
    regRead(3'd1, got); check("R1 latch", got, 8'h00);
    regRead(3'd2, got); check("R1 dir", got, 8'hFF);
    regRead(3'd3, got); check("R1 analog", got, 8'hFF);
    regRead(3'd4, got); check("R1 slew", got, 8'hFF);

    // R4 default analog: every pin reads 0 despite pad input high
    setPins(8'hFF);
    regRead(3'd0, got); check("R4 reset analog", got, 8'h00);

    // R3/R4 sweep: analog mask x all pad patterns
    for (int m = 0; m < 6; m++) begin
      regWrite(3'd3, masks[m]);
      for (int p = 0; p < 256; p++) begin
        setPins(8'(p));
        regRead(3'd0, got);
        check("R3 R4 port read", got, 8'(p) & ~masks[m]);
      end
    end
    // R4 walking single analog bit
    for (int b = 0; b < 8; b++) begin
      regWrite(3'd3, 8'(1 << b));
      setPins(8'hFF);
      regRead(3'd0, got);
      check("R4 walking analog", got, ~8'(1 << b));
    end

    // R2/R8 latch sweep, via both addresses, with opposing pins and full analog
    regWrite(3'd3, 8'hFF);
    for (int v = 0; v < 256; v++) begin
      regWrite(3'(v % 2), 8'(v));
      setPins(~8'(v));
      regRead(3'd1, got);
      check("R2 R8 latch readback", got, 8'(v));
      check("R2 padOut", padOut, 8'(v));
    end
    regWrite(3'd3, 8'h00);
    setPins(8'h3C);
    regRead(3'd1, got); check("R8 latch vs pins", got, 8'hFF);
    regRead(3'd0, got); check("R3 port vs latch", got, 8'h3C);

    // R6 direction sweep
    for (int v = 0; v < 256; v++) begin
      regWrite(3'd2, 8'(v));
      check("R6 padOe", padOe, ~8'(v));
      regRead(3'd2, got); check("R6 dir readback", got, 8'(v));
    end

    // R5 analog does not touch outputs
    regWrite(3'd0, 8'hA5);
    regWrite(3'd2, 8'h00);
    regWrite(3'd3, 8'hFF);
    check("R5 padOut under analog", padOut, 8'hA5);
    check("R5 padOe under analog", padOe, 8'hFF);
    regWrite(3'd3, 8'h00);
    check("R5 padOut after clear", padOut, 8'hA5);
    check("R5 padOe after clear", padOe, 8'hFF);

    // R9 slew
    for (int v = 0; v < 256; v += 17) begin
      regWrite(3'd4, 8'(v));
      check("R9 padSlowSlew", padSlowSlew, 8'(v));
      regRead(3'd4, got); check("R9 slew readback", got, 8'(v));
    end

    // R7 synchronizer latency with held read strobe
    regWrite(3'd3, 8'h00);
    setPins(8'h00);
    @(negedge clk);
    padIn = 8'h69; busAddr = 3'd0; busRdEn = 1'b1;
    @(negedge clk); check("R7 edge+1", rdData, 8'h00);
    @(negedge clk); check("R7 edge+2", rdData, 8'h00);
    @(negedge clk); check("R7 edge+3", rdData, 8'h69);
    busRdEn = 1'b0;

    // R11 hold without strobe
    padIn = 8'h12;
    busAddr = 3'd1;
    repeat (4) @(negedge clk);
    check("R11 hold", rdData, 8'h69);

    // R10 unmapped offsets
    regWrite(3'd0, 8'h5A); regWrite(3'd2, 8'hC3);
    regWrite(3'd3, 8'h18); regWrite(3'd4, 8'h7E);
    for (int a = 5; a < 8; a++) begin
      regWrite(3'(a), 8'(a * 37));
      regRead(3'(a), got); check("R10 unmapped read", got, 8'h00);
    end
    regRead(3'd1, got); check("R10 latch intact", got, 8'h5A);
    regRead(3'd2, got); check("R10 dir intact", got, 8'hC3);
    regRead(3'd3, got); check("R10 analog intact", got, 8'h18);
    regRead(3'd4, got); check("R10 slew intact", got, 8'h7E);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule